// File: doc/BRIEF.md
# Asynchronous Static Memory Port Controller

This block lets a clocked system read and write an external asynchronous static memory of 131,072 words by 24 bits. On the system side the caller pulses a request together with an address, a read/write flag and write data. The controller runs the access on the memory pins and answers with a one-cycle done pulse. For reads, the captured word appears on the read-data port in the same cycle as that pulse. The controller accepts a request only while idle. A request that arrives during an access is dropped.

On the memory side the controller drives a 17-bit address and three select lines. Two of the select lines are active-low and one is active-high. It also drives an active-low write strobe, an active-low output enable, and a data bus split into separate out, in and drive-enable signals. Every timing minimum is a parameter in nanoseconds, together with the clock period. The controller turns each minimum into a cycle count by dividing by the period and rounding up. Writes are timed by the write strobe, with the output enable held high. The controller drives the data bus only while the write strobe is low. When a read is followed by a write, idle cycles are inserted so that the memory's outputs have floated before the controller drives the bus.

Top module: `asram_ctrl`

## Requirements
- R1: After synchronous reset, and whenever no access is in progress, the select lines are deasserted (`mem_sel_a_n`=1, `mem_sel_b`=0, `mem_sel_c_n`=1). In that state `mem_we_n`=1, `mem_oe_n`=1, `mem_dq_oe`=0 and `rsp_done`=0.
- R2: The three select lines always switch together. During an access they show `mem_sel_a_n`=0, `mem_sel_b`=1, `mem_sel_c_n`=0, and no mixed pattern ever appears.
- R3: A read holds `mem_oe_n`=0 and `mem_we_n`=1 for RD_CYC = ceil(RD_NS/CLK_NS) cycles. The bus is sampled on the last of these cycles. `rsp_done` then rises RD_CYC+1 clock edges after the edge that accepted the request, with the sampled word on `rsp_rdata`.
- R4: A write holds `mem_we_n`=0 for WR_CYC cycles, with `mem_oe_n`=1 throughout. WR_CYC = max(ceil(WE_NS/CLK_NS), ceil(DS_NS/CLK_NS)). One recovery cycle follows, with `mem_we_n`=1 and the address and selects held. The memory word then holds the request's write data.
- R5: `mem_addr` stays unchanged for every cycle in which `mem_we_n` is low, and in the cycle in which it returns high.
- R6: `mem_dq_oe` is high only while `mem_we_n` is low. While it is high, `mem_dq_out` carries the accepted write data.
- R7: A write that follows a read first spends TURN_CYC = max(1, ceil(TURN_NS/CLK_NS)) cycles with all memory pins idle. `mem_dq_oe` is never high in the cycle after one in which `mem_oe_n` was low.
- R8: `rsp_done` is a single-cycle pulse, issued once for every accepted request.
- R9: A request presented while an access is in progress is ignored. It produces no done pulse and changes no memory word.
- R10: A write that follows a write, or follows reset, starts with no turnaround gap. Its `rsp_done` rises WR_CYC+2 edges after the accepting edge. After a read, a write's `rsp_done` rises TURN_CYC+WR_CYC+2 edges after the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | One-cycle request strobe, taken only when idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W | Read word, valid with `rsp_done` after a read |
| mem_addr | output | ADDR_W | Memory address |
| mem_sel_a_n | output | 1 | Active-low select line |
| mem_sel_b | output | 1 | Active-high select line |
| mem_sel_c_n | output | 1 | Active-low select line |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_dq_out | output | DATA_W | Data driven toward the memory |
| mem_dq_in | input | DATA_W | Data returned by the memory |
| mem_dq_oe | output | 1 | Drive enable for `mem_dq_out` |

## Verification
A wrong sequencer state shows up at the memory pins in the very next cycle. It can appear as a mixed select pattern, as the data drivers on while the write strobe is high, or as the drivers on right after the output enable was low. A bus monitor in the bench catches these at once. A wrong cycle counter shows up within one access as a done pulse that is early or late against the latency computed from the parameters. A wrong capture point or a wrong write path shows up as a mismatched word on the next read of that address. The sweeps cover every address, both after writes and after reads.

// File: rtl/asram_pkg.sv
package asram_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_TURN  = 3'd1,
        ST_WRITE = 3'd2,
        ST_WREC  = 3'd3,
        ST_READ  = 3'd4
    } asram_state_e;

    // cycles needed to cover a nanosecond minimum, rounded up, at least one
    function automatic int ns_to_cyc(input int ns, input int clk_ns);
        int c;
        c = (ns + clk_ns - 1) / clk_ns;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int max_int(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/asram_cyc_timer.sv
module asram_cyc_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             last
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end else begin
            cnt_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign last = (cnt_q == CNT_W'(1));

endmodule

// File: rtl/asram_sel_map.sv
module asram_sel_map #(
    parameter int               N_SEL    = 3,
    parameter logic [N_SEL-1:0] ACT_HIGH = 3'b010
) (
    input  logic             sel,
    output logic [N_SEL-1:0] pins
);

    for (genvar i = 0; i < N_SEL; i++) begin : g_pin
        if (ACT_HIGH[i]) begin : g_hi
            assign pins[i] = sel;
        end else begin : g_lo
            assign pins[i] = ~sel;
        end
    end

endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
    import asram_pkg::*;
#(
    parameter int ADDR_W  = 17,
    parameter int DATA_W  = 24,
    parameter int CLK_NS  = 5,
    parameter int RD_NS   = 10,
    parameter int WE_NS   = 8,
    parameter int DS_NS   = 4,
    parameter int TURN_NS = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_done,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_sel_a_n,
    output logic              mem_sel_b,
    output logic              mem_sel_c_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [DATA_W-1:0] mem_dq_out,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic              mem_dq_oe
);

    localparam int RD_CYC   = ns_to_cyc(RD_NS, CLK_NS);
    localparam int WR_CYC   = max_int(ns_to_cyc(WE_NS, CLK_NS), ns_to_cyc(DS_NS, CLK_NS));
    localparam int TURN_CYC = ns_to_cyc(TURN_NS, CLK_NS);
    localparam int MAX_CYC  = max_int(RD_CYC, max_int(WR_CYC, TURN_CYC));
    localparam int CNT_W    = $clog2(MAX_CYC + 1);

    typedef struct packed {
        asram_state_e      st;
        logic              last_rd;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wd;
        logic              sel;
        logic              we_n;
        logic              oe_n;
        logic              dq_oe;
        logic [DATA_W-1:0] rd;
        logic              done;
    } regs_t;

    regs_t            r_d, r_q;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_last;
    logic [2:0]       sel_pins;

    asram_cyc_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .last     (tmr_last)
    );

    asram_sel_map #(.N_SEL(3), .ACT_HIGH(3'b010)) u_sel_map (
        .sel  (r_q.sel),
        .pins (sel_pins)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        tmr_load = 1'b0;
        tmr_val  = '0;
        case (r_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.addr = req_addr;
                    r_d.wd   = req_wdata;
                    if (req_write) begin
                        if (r_q.last_rd) begin
                            r_d.st   = ST_TURN;
                            tmr_load = 1'b1;
                            tmr_val  = CNT_W'(TURN_CYC);
                        end else begin
                            r_d.st    = ST_WRITE;
                            r_d.sel   = 1'b1;
                            r_d.we_n  = 1'b0;
                            r_d.dq_oe = 1'b1;
                            tmr_load  = 1'b1;
                            tmr_val   = CNT_W'(WR_CYC);
                        end
                    end else begin
                        r_d.st   = ST_READ;
                        r_d.sel  = 1'b1;
                        r_d.oe_n = 1'b0;
                        tmr_load = 1'b1;
                        tmr_val  = CNT_W'(RD_CYC);
                    end
                end
            end
            ST_TURN: begin
                if (tmr_last) begin
                    r_d.st    = ST_WRITE;
                    r_d.sel   = 1'b1;
                    r_d.we_n  = 1'b0;
                    r_d.dq_oe = 1'b1;
                    tmr_load  = 1'b1;
                    tmr_val   = CNT_W'(WR_CYC);
                end
            end
            ST_WRITE: begin
                if (tmr_last) begin
                    r_d.st    = ST_WREC;
                    r_d.we_n  = 1'b1;
                    r_d.dq_oe = 1'b0;
                end
            end
            ST_WREC: begin
                r_d.st      = ST_IDLE;
                r_d.sel     = 1'b0;
                r_d.done    = 1'b1;
                r_d.last_rd = 1'b0;
            end
            ST_READ: begin
                if (tmr_last) begin
                    r_d.st      = ST_IDLE;
                    r_d.rd      = mem_dq_in;
                    r_d.sel     = 1'b0;
                    r_d.oe_n    = 1'b1;
                    r_d.done    = 1'b1;
                    r_d.last_rd = 1'b1;
                end
            end
            default: begin
                r_d.st    = ST_IDLE;
                r_d.sel   = 1'b0;
                r_d.we_n  = 1'b1;
                r_d.oe_n  = 1'b1;
                r_d.dq_oe = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q.st      <= ST_IDLE;
            r_q.last_rd <= 1'b0;
            r_q.addr    <= '0;
            r_q.wd      <= '0;
            r_q.sel     <= 1'b0;
            r_q.we_n    <= 1'b1;
            r_q.oe_n    <= 1'b1;
            r_q.dq_oe   <= 1'b0;
            r_q.rd      <= '0;
            r_q.done    <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign rsp_done    = r_q.done;
    assign rsp_rdata   = r_q.rd;
    assign mem_addr    = r_q.addr;
    assign mem_sel_a_n = sel_pins[0];
    assign mem_sel_b   = sel_pins[1];
    assign mem_sel_c_n = sel_pins[2];
    assign mem_we_n    = r_q.we_n;
    assign mem_oe_n    = r_q.oe_n;
    assign mem_dq_out  = r_q.wd;
    assign mem_dq_oe   = r_q.dq_oe;

endmodule

// File: rtl/asram_ctrl_chk.sv
module asram_ctrl_chk #(
    parameter int ADDR_W = 17,
    parameter int WR_CYC = 2,
    parameter int RD_CYC = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              rsp_done,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_sel_a_n,
    input logic              mem_sel_b,
    input logic              mem_sel_c_n,
    input logic              mem_we_n,
    input logic              mem_oe_n,
    input logic              mem_dq_oe
);

    logic [15:0] we_low_cnt, oe_low_cnt;
    logic        selected;

    assign selected = !mem_sel_a_n && mem_sel_b && !mem_sel_c_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            we_low_cnt <= '0;
            oe_low_cnt <= '0;
        end else begin
            we_low_cnt <= mem_we_n ? 16'd0 : we_low_cnt + 16'd1;
            oe_low_cnt <= mem_oe_n ? 16'd0 : oe_low_cnt + 16'd1;
        end
    end

    // R1
    idle_pins_chk: assert property (@(posedge clk) disable iff (rst)
        !selected |-> (mem_we_n && mem_oe_n && !mem_dq_oe));

    // R2
    sel_agree_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_sel_a_n == !mem_sel_b) && (mem_sel_c_n == !mem_sel_b));

    // R3
    read_len_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_oe_n) |-> (oe_low_cnt >= 16'(RD_CYC)));

    // R4
    write_len_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_we_n) |-> (we_low_cnt >= 16'(WR_CYC)));

    // R4
    oe_off_write_chk: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |-> mem_oe_n);

    // R5
    addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!mem_we_n && $past(!mem_we_n)) |-> $stable(mem_addr));

    // R5
    addr_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_we_n) |-> $stable(mem_addr));

    // R6
    drive_in_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        mem_dq_oe |-> !mem_we_n);

    // R7
    turnaround_chk: assert property (@(posedge clk) disable iff (rst)
        $past(!mem_oe_n) |-> !mem_dq_oe);

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_done |=> !rsp_done);

endmodule

bind asram_ctrl asram_ctrl_chk #(
    .ADDR_W (ADDR_W),
    .WR_CYC (WR_CYC),
    .RD_CYC (RD_CYC)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .rsp_done    (rsp_done),
    .mem_addr    (mem_addr),
    .mem_sel_a_n (mem_sel_a_n),
    .mem_sel_b   (mem_sel_b),
    .mem_sel_c_n (mem_sel_c_n),
    .mem_we_n    (mem_we_n),
    .mem_oe_n    (mem_oe_n),
    .mem_dq_oe   (mem_dq_oe)
);

// File: tb/asram_ctrl_bench.sv
module asram_ctrl_bench;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 6;
    localparam int DW = 8;
    localparam int DEPTH = 1 << AW;
    localparam int P_CLK = 5, P_RD = 10, P_WE = 8, P_DS = 4, P_TURN = 5;
    localparam int E_RD = (P_RD + P_CLK - 1) / P_CLK;
    localparam int E_WE = (P_WE + P_CLK - 1) / P_CLK;
    localparam int E_DS = (P_DS + P_CLK - 1) / P_CLK;
    localparam int E_WR = (E_WE > E_DS) ? E_WE : E_DS;
    localparam int E_TRN_RAW = (P_TURN + P_CLK - 1) / P_CLK;
    localparam int E_TRN = (E_TRN_RAW < 1) ? 1 : E_TRN_RAW;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0;
    logic req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic rsp_done;
    logic [DW-1:0] rsp_rdata;
    logic [AW-1:0] mem_addr;
    logic mem_sel_a_n, mem_sel_b, mem_sel_c_n, mem_we_n, mem_oe_n, mem_dq_oe;
    logic [DW-1:0] mem_dq_out, mem_dq_in;

    int checks = 0;
    int fails = 0;
    bit finished = 0;
    bit mon_on = 0;
    int v_mix = 0, v_drive = 0, v_cont = 0, v_oewr = 0, v_done = 0, v_turn = 0, v_idle = 0;
    logic prev_done = 1'b0, prev_oe_low = 1'b0;

    logic [DW-1:0] mem [DEPTH];
    logic mem_selected, mem_drives;

    always #(CLK_PERIOD / 2) clk = ~clk;

    asram_ctrl #(
        .ADDR_W (AW), .DATA_W (DW), .CLK_NS (P_CLK), .RD_NS (P_RD),
        .WE_NS (P_WE), .DS_NS (P_DS), .TURN_NS (P_TURN)
    ) u_asram_ctrl (
        .clk (clk), .rst (rst), .req_valid (req_valid), .req_write (req_write),
        .req_addr (req_addr), .req_wdata (req_wdata), .rsp_done (rsp_done),
        .rsp_rdata (rsp_rdata), .mem_addr (mem_addr), .mem_sel_a_n (mem_sel_a_n),
        .mem_sel_b (mem_sel_b), .mem_sel_c_n (mem_sel_c_n), .mem_we_n (mem_we_n),
        .mem_oe_n (mem_oe_n), .mem_dq_out (mem_dq_out), .mem_dq_in (mem_dq_in),
        .mem_dq_oe (mem_dq_oe)
    );

    // memory model: selected only with the active-low/high/low pattern
    assign mem_selected = !mem_sel_a_n && mem_sel_b && !mem_sel_c_n;
    assign mem_drives   = mem_selected && !mem_oe_n && mem_we_n;
    assign mem_dq_in    = mem_drives ? mem[mem_addr] : '0;

    always @(negedge clk) begin
        if (mem_selected && !mem_we_n && mem_dq_oe) mem[mem_addr] <= mem_dq_out;
        if (mon_on) begin
            if (!((mem_sel_a_n == !mem_sel_b) && (mem_sel_c_n == !mem_sel_b))) v_mix++;
            if (mem_dq_oe && mem_we_n) v_drive++;
            if (mem_dq_oe && mem_drives) v_cont++;
            if (!mem_we_n && !mem_oe_n) v_oewr++;
            if (rsp_done && prev_done) v_done++;
            if (prev_oe_low && mem_dq_oe) v_turn++;
            if (!mem_selected && (!mem_we_n || !mem_oe_n || mem_dq_oe)) v_idle++;
        end
        prev_done   <= rsp_done;
        prev_oe_low <= !mem_oe_n;
    end

    function automatic logic [DW-1:0] pat(input int a, input int k);
        return DW'((a * 29 + 7 + k * 91) ^ (k * 8'h5a));
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // issue one request; lat counts clock edges from the accepting edge to done visible
    task automatic do_op(input bit wr, input int a, input logic [DW-1:0] d,
                         output int lat, output logic [DW-1:0] rdv);
        int guard;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = AW'(a); req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        guard = 0;
        while (!rsp_done && guard < 100) begin
            @(negedge clk);
            lat++;
            guard++;
        end
        rdv = rsp_rdata;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int lat;
        int ndone;
        logic [DW-1:0] rv;
        for (int i = 0; i < DEPTH; i++) mem[i] = '1;
        repeat (4) @(negedge clk);
        // R1: reset state
        chk(mem_sel_a_n && !mem_sel_b && mem_sel_c_n, "R1", "reset selects",
            {mem_sel_a_n, mem_sel_b, mem_sel_c_n}, 3'b101);
        chk(mem_we_n && mem_oe_n && !mem_dq_oe && !rsp_done, "R1", "reset strobes",
            {mem_we_n, mem_oe_n, mem_dq_oe, rsp_done}, 4'b1100);
        rst = 1'b0;
        mon_on = 1'b1;

        // R4 R10: write sweep, write after reset / after write
        for (int a = 0; a < DEPTH; a++) begin
            do_op(1'b1, a, pat(a, 0), lat, rv);
            chk(lat == E_WR + 2, "R10", "write-after-write latency", lat, E_WR + 2);
        end
        for (int a = 0; a < DEPTH; a++)
            chk(mem[a] == pat(a, 0), "R4", "stored word", mem[a], pat(a, 0));

        // R3: read sweep
        for (int a = 0; a < DEPTH; a++) begin
            do_op(1'b0, a, '0, lat, rv);
            chk(lat == E_RD + 1, "R3", "read latency", lat, E_RD + 1);
            chk(rv == pat(a, 0), "R3", "read data", rv, pat(a, 0));
        end

        // R7 R10: write after read, then read after write
        for (int a = 0; a < DEPTH; a++) begin
            do_op(1'b0, a, '0, lat, rv);
            chk(rv == pat(a, 0), "R3", "read before overwrite", rv, pat(a, 0));
            do_op(1'b1, a, pat(a, 1), lat, rv);
            chk(lat == E_TRN + E_WR + 2, "R7", "write-after-read latency", lat, E_TRN + E_WR + 2);
            do_op(1'b0, a, '0, lat, rv);
            chk(rv == pat(a, 1), "R4", "read after write", rv, pat(a, 1));
            chk(lat == E_RD + 1, "R10", "read-after-write latency", lat, E_RD + 1);
        end

        // R9: request during an access is ignored
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = AW'(3); req_wdata = 8'hc3;
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = AW'(9); req_wdata = 8'h3c;
        @(negedge clk);
        req_valid = 1'b0;
        ndone = 0;
        for (int c = 0; c < 12; c++) begin
            if (rsp_done) ndone++;
            @(negedge clk);
        end
        chk(ndone == 1, "R9", "done pulses for overlapped request", ndone, 1);
        do_op(1'b0, 9, '0, lat, rv);
        chk(rv == pat(9, 1), "R9", "ignored write left word", rv, pat(9, 1));
        do_op(1'b0, 3, '0, lat, rv);
        chk(rv == 8'hc3, "R9", "accepted write stored", rv, 8'hc3);

        repeat (3) @(negedge clk);
        chk(v_mix == 0, "R2", "mixed select cycles", v_mix, 0);
        chk(v_drive == 0 && v_cont == 0, "R6", "drive outside pulse or contention", v_drive + v_cont, 0);
        chk(v_oewr == 0, "R4", "output enable low during write", v_oewr, 0);
        chk(v_done == 0, "R8", "done wider than one cycle", v_done, 0);
        chk(v_turn == 0, "R7", "drive right after output enable", v_turn, 0);
        chk(v_idle == 0, "R1", "strobes active while deselected", v_idle, 0);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule